// File: doc/BRIEF.md
# Serial Frame Port Timing Master

This block drives the timing side of a bidirectional serial data port that joins a converter front end to a DSP host. It runs entirely on the system clock. A divider produces the serial bit clock `bclk` at one eighteenth of the system clock. A frame state machine counts 256 bit periods per frame and shapes an active-low frame sync `fsync_n`. Two shift paths move data: each frame, one 16-bit transmit word goes out on `sdout` and one 16-bit receive word is collected from `sdin`.

The host side writes the next outgoing word into a holding register at any time with `tx_write`. The block copies that register into the transmit shifter at the start of each frame and acknowledges the copy with `tx_taken`. A finished receive word appears on `rx_data` together with a one-cycle `rx_valid` strobe.

A strap input chooses the frame-sync style. With the strap high, the sync is a short pulse lasting one bit period just before the data. With the strap low, the sync stays low across all sixteen data periods, like a chip select. The strap is latched only while reset is held.

The state machine has three states:
- `ST_IDLE` covers periods 17 to 255. It is also the state after reset.
- `ST_SYNC` covers period 0.
- `ST_DATA` covers periods 1 to 16.

All transitions happen on a bit-clock rising tick:
- IDLE to SYNC, named *frame_wrap*, when period 255 ends.
- SYNC to DATA, named *data_open*, after one period.
- DATA to IDLE, named *data_close*, when period 16 ends.

Top module: `sfp_timing_master`

## Requirements
- R1: `bclk` has a period of exactly 18 system clocks. It is high for the first 9 clocks of each bit period and low for the last 9. Its first rising edge occurs on the first system clock edge after reset release.
- R2: Every frame spans exactly 256 bit periods, numbered 0 to 255. Period 0 is the sync period. Periods 1 to 16 carry data. Periods 17 to 255 are idle. Frames repeat without gaps, so one frame lasts 4608 system clocks.
- R3: In early mode (strap latched high), `fsync_n` is low during period 0 only and high in all other periods.
- R4: In late mode (strap latched low), `fsync_n` is low during periods 1 to 16 and high in all other periods.
- R5: `mode_strap` is sampled on each clock edge while `rst_n` is low. The last sampled value selects the mode until the next reset. Changes to the strap after reset release have no effect on `fsync_n`.
- R6: `sdout` sends the loaded word most significant bit first. Bit 15 is driven in period 1 and bit 0 in period 16. `sdout` changes only together with a rising `bclk` and is 0 in every non-data period.
- R7: A pulse on `tx_write` stores `tx_data` in the holding register. The holding register is copied into the transmit shifter on the clock edge that starts period 0, and `tx_taken` pulses for one clock right after that edge. If a write falls on that same edge, the copy takes the previous content and the new word goes out in the next frame.
- R8: `sdin` is sampled when `bclk` falls, in periods 1 to 16, with the first sample becoming bit 15. When the 16th bit is captured, `rx_data` shows the word and `rx_valid` is high for exactly one system clock.
- R9: While reset is held, `bclk` is 0, `fsync_n` is 1, `sdout` is 0, and `rx_valid` and `tx_taken` are 0.
- R10: `sdin` during periods 0 and 17 to 255 is ignored: `rx_data` keeps its last word and `rx_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_strap | input | 1 | Frame-sync style strap: 1 early pulse, 0 chip-select style |
| tx_data | input | 16 | Next outgoing word |
| tx_write | input | 1 | Stores `tx_data` in the holding register |
| tx_taken | output | 1 | One-cycle pulse after the holding word is copied for a frame |
| rx_data | output | 16 | Last complete received word |
| rx_valid | output | 1 | One-cycle strobe when `rx_data` is updated |
| bclk | output | 1 | Serial bit clock |
| fsync_n | output | 1 | Active-low frame sync |
| sdout | output | 1 | Serial transmit data |
| sdin | input | 1 | Serial receive data |

## Verification
Two functions can land on the same system clock edge: a host write into the holding register, and the frame-start copy of that register into the transmit shifter. The bench schedules a write exactly on the frame-start edge every third frame. In the other frames it schedules the write during the data periods or during the idle periods. A bench model keeps its own holding value and decides, by edge order alone, which word each frame must serialize. Every bit on `sdout` is then compared against that word, so a copy that picks up the fresh write, or a write that is lost, shows up as a wrong bit.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SYNC = 2'd1,
        ST_DATA = 2'd2
    } sfp_state_e;
endpackage

// File: rtl/sfp_bitclk_div.sv
module sfp_bitclk_div #(
    parameter int DIV = 18
) (
    input  logic clk,
    input  logic rst_n,
    output logic bclk_o,
    output logic rise_evt_o,
    output logic fall_evt_o
);
    localparam int DIV_W = $clog2(DIV);
    localparam int HALF  = DIV / 2;
    localparam logic [DIV_W-1:0] CNT_LAST = DIV_W'(DIV - 1);
    localparam logic [DIV_W-1:0] CNT_FALL = DIV_W'(HALF - 1);
    localparam logic [DIV_W-1:0] CNT_HALF = DIV_W'(HALF);

    logic [DIV_W-1:0] cnt_q, cnt_nxt;
    logic             bclk_q;

    // The next count value decides the next level of the bit clock.
    always_comb begin
        cnt_nxt = (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= CNT_LAST;
            bclk_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_nxt;
            bclk_q <= (cnt_nxt < CNT_HALF);
        end
    end

    assign bclk_o     = bclk_q;
    assign rise_evt_o = (cnt_q == CNT_LAST);
    assign fall_evt_o = (cnt_q == CNT_FALL);

    AST_BCLK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_evt_o |=> bclk_q); // R1
    AST_BCLK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        fall_evt_o |=> !bclk_q); // R1
endmodule

// File: rtl/sfp_frame_fsm.sv
module sfp_frame_fsm
    import sfp_pkg::*;
#(
    parameter int FRAME_BITS = 256,
    parameter int WORD_W     = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_strap,
    input  logic       rise_evt,
    output sfp_state_e state_o,
    output logic       frame_start_o,
    output logic       shift_evt_o,
    output logic       rx_last_o,
    output logic       fsync_n_o
);
    localparam int BIT_W = $clog2(FRAME_BITS);
    localparam logic [BIT_W-1:0] PER_LAST = BIT_W'(FRAME_BITS - 1);
    localparam logic [BIT_W-1:0] PER_DEND = BIT_W'(WORD_W);

    sfp_state_e       state_q, state_nxt;
    logic [BIT_W-1:0] per_q;
    logic             mode_early_q;
    logic             fsync_n_q;

    // The strap is latched only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_early_q <= mode_strap;
    end

    // State register and bit-period counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            per_q   <= PER_LAST;
        end else begin
            state_q <= state_nxt;
            if (rise_evt) per_q <= (per_q == PER_LAST) ? '0 : per_q + 1'b1;
        end
    end

    // Transitions: frame_wrap, data_open, data_close.
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE: if (rise_evt && per_q == PER_LAST) state_nxt = ST_SYNC;
            ST_SYNC: if (rise_evt)                      state_nxt = ST_DATA;
            ST_DATA: if (rise_evt && per_q == PER_DEND) state_nxt = ST_IDLE;
            default:                                    state_nxt = ST_IDLE;
        endcase
    end

    // Output process: the frame sync follows the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsync_n_q <= 1'b1;
        end else if (mode_early_q) begin
            fsync_n_q <= (state_nxt != ST_SYNC);
        end else begin
            fsync_n_q <= (state_nxt != ST_DATA);
        end
    end

    assign state_o       = state_q;
    assign frame_start_o = (state_q == ST_IDLE) && (state_nxt == ST_SYNC);
    assign shift_evt_o   = rise_evt && (state_nxt == ST_DATA);
    assign rx_last_o     = (state_q == ST_DATA) && (per_q == PER_DEND);
    assign fsync_n_o     = fsync_n_q;

    AST_SYNC_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SYNC) |-> (per_q == '0)); // R2
    AST_EARLY_ONE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_early_q && !fsync_n_q && rise_evt) |=> fsync_n_q); // R3
    AST_LATE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_early_q && state_q == ST_DATA) |-> !fsync_n_q); // R4
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_early_q)); // R5
endmodule

// File: rtl/sfp_shifter.sv
module sfp_shifter
    import sfp_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sfp_state_e        state,
    input  logic              rise_evt,
    input  logic              fall_evt,
    input  logic              frame_start,
    input  logic              shift_evt,
    input  logic              rx_last,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_write,
    input  logic              sdin,
    output logic              sdout_o,
    output logic              tx_taken_o,
    output logic [WORD_W-1:0] rx_data_o,
    output logic              rx_valid_o
);
    logic [WORD_W-1:0] hold_q, tx_sh_q, rx_sh_q, rx_word_q;
    logic              sdout_q, taken_q, rx_valid_q;
    logic              sample_evt;

    assign sample_evt = fall_evt && (state == ST_DATA);

    // Holding register and transmit path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= '0;
            tx_sh_q <= '0;
            sdout_q <= 1'b0;
            taken_q <= 1'b0;
        end else begin
            if (tx_write) hold_q <= tx_data;
            taken_q <= frame_start;
            if (frame_start) begin
                tx_sh_q <= hold_q;
                sdout_q <= 1'b0;
            end else if (shift_evt) begin
                sdout_q <= tx_sh_q[WORD_W-1];
                tx_sh_q <= {tx_sh_q[WORD_W-2:0], 1'b0};
            end else if (rise_evt) begin
                sdout_q <= 1'b0;
            end
        end
    end

    // Receive path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh_q    <= '0;
            rx_word_q  <= '0;
            rx_valid_q <= 1'b0;
        end else begin
            rx_valid_q <= 1'b0;
            if (sample_evt) begin
                rx_sh_q <= {rx_sh_q[WORD_W-2:0], sdin};
                if (rx_last) begin
                    rx_word_q  <= {rx_sh_q[WORD_W-2:0], sdin};
                    rx_valid_q <= 1'b1;
                end
            end
        end
    end

    assign sdout_o    = sdout_q;
    assign tx_taken_o = taken_q;
    assign rx_data_o  = rx_word_q;
    assign rx_valid_o = rx_valid_q;

    AST_IDLE_LINE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_DATA) |-> !sdout_q); // R6
    AST_TAKEN_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        taken_q |-> (state == ST_SYNC)); // R7
    AST_RXV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_q |=> !rx_valid_q); // R8
    AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid_q |-> $stable(rx_word_q)); // R10
endmodule

// File: rtl/sfp_timing_master.sv
module sfp_timing_master
    import sfp_pkg::*;
#(
    parameter int DIV        = 18,
    parameter int FRAME_BITS = 256,
    parameter int WORD_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_strap,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_write,
    output logic              tx_taken,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              bclk,
    output logic              fsync_n,
    output logic              sdout,
    input  logic              sdin
);
    logic       rise_evt, fall_evt;
    logic       frame_start, shift_evt, rx_last;
    sfp_state_e state;

    sfp_bitclk_div #(.DIV(DIV)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk_o     (bclk),
        .rise_evt_o (rise_evt),
        .fall_evt_o (fall_evt)
    );

    sfp_frame_fsm #(.FRAME_BITS(FRAME_BITS), .WORD_W(WORD_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_strap    (mode_strap),
        .rise_evt      (rise_evt),
        .state_o       (state),
        .frame_start_o (frame_start),
        .shift_evt_o   (shift_evt),
        .rx_last_o     (rx_last),
        .fsync_n_o     (fsync_n)
    );

    sfp_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .state       (state),
        .rise_evt    (rise_evt),
        .fall_evt    (fall_evt),
        .frame_start (frame_start),
        .shift_evt   (shift_evt),
        .rx_last     (rx_last),
        .tx_data     (tx_data),
        .tx_write    (tx_write),
        .sdin        (sdin),
        .sdout_o     (sdout),
        .tx_taken_o  (tx_taken),
        .rx_data_o   (rx_data),
        .rx_valid_o  (rx_valid)
    );
endmodule

// File: tb/tb_sfp_timing_master.sv
module tb_sfp_timing_master;
    localparam int DIV   = 18;
    localparam int NPER  = 256;
    localparam int WW    = 16;
    localparam int FRAME = DIV * NPER;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_strap = 1'b1;
    logic [WW-1:0] tx_data = '0;
    logic          tx_write = 1'b0;
    logic          tx_taken;
    logic [WW-1:0] rx_data;
    logic          rx_valid;
    logic          bclk, fsync_n, sdout;
    logic          sdin = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    sfp_timing_master dut (
        .clk(clk), .rst_n(rst_n), .mode_strap(mode_strap),
        .tx_data(tx_data), .tx_write(tx_write), .tx_taken(tx_taken),
        .rx_data(rx_data), .rx_valid(rx_valid), .bclk(bclk),
        .fsync_n(fsync_n), .sdout(sdout), .sdin(sdin)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] rx_pat(input int f);
        if (f == 1) return 16'hFFFF;
        if (f == 2) return 16'h0001;
        return 16'hC35A ^ WW'(f * 16'h0F1D);
    endfunction

    // One reset plus several frames in a given mode.
    task automatic run_segment(input bit early, input int nframes);
        logic [WW-1:0] hold_m = '0;
        logic [WW-1:0] cur_tx = '0;
        logic [WW-1:0] rx_m   = '0;
        int wcount = 0;
        int n = 0;
        rst_n = 1'b0;
        tx_write = 1'b0;
        for (int i = 0; i < 6; i++) begin
            mode_strap = i[0];
            @(negedge clk);
            chk(bclk == 1'b0 && fsync_n == 1'b1 && sdout == 1'b0 &&
                rx_valid == 1'b0 && tx_taken == 1'b0, "R9 reset state",
                {bclk, fsync_n, sdout, rx_valid, tx_taken}, 5'b01000);
        end
        mode_strap = early;
        @(negedge clk);
        rst_n = 1'b1;
        mode_strap = ~early; // R5: changes after release must be ignored
        n = 0;
        while (n < nframes * FRAME + 40) begin
            // Drive for edge n+1.
            begin
                int f2 = n / FRAME;
                int off = n % FRAME;
                int p2 = (n / DIV) % NPER;
                int sched = (f2 % 3 == 0) ? 0 : ((f2 % 3 == 1) ? 150 : 3000);
                if (off == 0) cur_tx = hold_m; // R7 copy uses pre-edge content
                tx_write = (off == sched);
                tx_data  = tx_write ? WW'(16'h8001 + wcount * 16'h2467) : WW'($urandom);
                if (tx_write) begin
                    hold_m = tx_data;
                    wcount++;
                end
                if (p2 >= 1 && p2 <= WW) sdin = rx_pat(f2)[WW - p2];
                else sdin = 1'($urandom); // R10 noise outside data periods
                if (n % 997 == 13) mode_strap = ~mode_strap;
            end
            @(negedge clk);
            n++;
            begin
                int d = (n - 1) % DIV;
                int p = ((n - 1) / DIV) % NPER;
                int f = (n - 1) / FRAME;
                bit exp_fs, exp_sd, exp_rv, exp_tk;
                exp_fs = early ? (p != 0) : !(p >= 1 && p <= WW);
                exp_sd = (p >= 1 && p <= WW) ? cur_tx[WW - p] : 1'b0;
                exp_rv = (d == DIV / 2) && (p == WW);
                exp_tk = (d == 0) && (p == 0);
                if (exp_rv) rx_m = rx_pat(f);
                chk(bclk == (d < DIV / 2), "R1 bit clock", bclk, (d < DIV / 2));
                chk(fsync_n == exp_fs, early ? "R3 early sync (R2 R5)" : "R4 late sync (R2 R5)",
                    fsync_n, exp_fs);
                chk(sdout == exp_sd, "R6 serial out (R7 word)", sdout, exp_sd);
                chk(tx_taken == exp_tk, "R7 taken pulse", tx_taken, exp_tk);
                chk(rx_valid == exp_rv, "R8 rx valid", rx_valid, exp_rv);
                chk(rx_data == rx_m, "R8 R10 rx word", rx_data, rx_m);
            end
        end
    endtask

    initial begin
        run_segment(1'b1, 3);
        run_segment(1'b0, 3);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule